// File: doc/BRIEF.md
# Narrow External Memory Packing Port

This block connects a word-oriented internal requester to an asynchronous external memory whose data bus is only 8 or 16 bits wide. The requester offers one 32-bit word at a time over a valid/ready handshake, together with a word address and a read/write flag. The port splits a write word into narrow pieces, or gathers the narrow pieces of a read into one word. It drives the external address, the read and write strobes and a data-direction enable. The requester only ever sees whole 32-bit words.

No acknowledge comes back from the external memory. Every access is timed by the port alone. The strobe of each access stays high for a programmed number of clock cycles, and an idle cycle always follows it. The port remembers the last external address it used. When an access continues a run of consecutive addresses into a new 256-entry page, the port inserts one extra idle cycle before that access and flags it.

The lane width and the access duration are sampled when a word is accepted. They stay fixed until every piece of that word has been transferred.

Top module: `xmem_pack_port`

## Requirements
- R1: `req_ready` is high exactly when no word is in progress. After reset it is high, and both strobes, `page_cross`, `xm_drive` and `rsp_valid` are low. A word is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` falls in the next cycle.
- R2: With `cfg_lane16`=0 a word at word address W becomes four accesses at external addresses 4W, 4W+1, 4W+2 and 4W+3, in that order. On a write, access k drives data bits [8k+7:8k] on `xm_dout[7:0]`, with `xm_dout[15:8]`=0.
- R3: With `cfg_lane16`=1 a word at word address W becomes two accesses at external addresses 2W and 2W+1. On a write, access k drives data bits [16k+15:16k] on `xm_dout`.
- R4: During each access exactly one of `xm_rd` (read) and `xm_wr` (write) is high, for D consecutive cycles, and `xm_addr` stays stable for the whole access.
- R5: D is the `cfg_dur` value sampled at acceptance, with values below 3 raised to 3 and values above 32 lowered to 32.
- R6: After every access both strobes are low for at least one cycle. Within a word, the next access starts after exactly one idle cycle, unless R8 adds one more.
- R7: On a read, `rsp_valid` pulses high for one cycle, in the cycle right after the last strobe cycle, with `rsp_data` assembled least-significant piece first. In 8-bit mode `xm_din[15:8]` is ignored.
- R8: An access whose external address has its low 8 bits at zero, and whose address is one above the previous access since reset, is preceded by one extra idle cycle in which `page_cross` is high. Every other idle cycle has `page_cross` low.
- R9: `xm_drive` is high in every cycle from the cycle after a write word is accepted through the idle cycle after its last access, and low at all other times. It is never high together with `xm_rd`.
- R10: Changes of `cfg_lane16` or `cfg_dur` while a word is in progress do not change that word's accesses.
- R11: `rsp_valid` never rises for a write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lane16 | input | 1 | External lane width: 0 = 8 bits, 1 = 16 bits |
| cfg_dur | input | 6 | Requested strobe length in cycles, clamped to 3..32 |
| req_valid | input | 1 | Requester offers a word |
| req_ready | output | 1 | Port is idle and takes the offered word |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_waddr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read word complete |
| rsp_data | output | 32 | Assembled read word |
| xm_addr | output | AW+2 | External address of the current access |
| xm_rd | output | 1 | Read strobe, active high |
| xm_wr | output | 1 | Write strobe, active high |
| xm_drive | output | 1 | Port drives the external data lines |
| xm_dout | output | 16 | Write data lane |
| xm_din | input | 16 | Read data lane |
| page_cross | output | 1 | High during the idle cycle inserted at a page boundary |

## Verification
A wrong value in the strobe down-counter shows as a strobe that is one or more cycles too short or too long, within the access it affects. A wrong piece counter shows at the next idle cycle, either as a missing or extra access or as `req_ready` returning at the wrong time. A fault in the lane shift register shows on `xm_dout` during the very next write access, or on `rsp_data` at the response pulse of a read. A stale previous-address register shows as a missing or spurious `page_cross` idle cycle at the next boundary. The bench therefore compares every port against a behavioural model in every cycle, and it also compares the final external memory image.

// File: rtl/xpp_pkg.sv
package xpp_pkg;

    localparam int WORD_W   = 32;
    localparam int LANE_W   = 16;
    localparam int DUR_W    = 6;
    localparam int DUR_LO   = 3;
    localparam int DUR_HI   = 32;
    localparam int PAGE_LSB = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAGE = 2'd1,
        ST_ACC  = 2'd2,
        ST_GAP  = 2'd3
    } xpp_state_e;

    typedef enum logic {
        LANE8  = 1'b0,
        LANE16 = 1'b1
    } lane_e;

    typedef struct packed {
        logic             wr;
        lane_e            lane;
        logic [DUR_W-1:0] dur;
    } job_t;

    function automatic logic [DUR_W-1:0] clamp_dur(input logic [DUR_W-1:0] raw);
        if (raw < DUR_W'(DUR_LO)) return DUR_W'(DUR_LO);
        if (raw > DUR_W'(DUR_HI)) return DUR_W'(DUR_HI);
        return raw;
    endfunction

    function automatic logic [2:0] piece_cnt(input lane_e l);
        return (l == LANE16) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/xpp_timer.sv
module xpp_timer
    import xpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DUR_W-1:0] dur,
    output logic             last
);

    logic [DUR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= dur;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == DUR_W'(1));

    // R5: the strobe counter never holds more than the longest legal duration
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= DUR_W'(DUR_HI));

endmodule

// File: rtl/xpp_pack.sv
module xpp_pack
    import xpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  lane_e             lane,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (load)
            sh <= wdata;
        else if (step) begin
            if (lane == LANE16)
                sh <= {din, sh[WORD_W-1:LANE_W]};
            else
                sh <= {din[7:0], sh[WORD_W-1:8]};
        end
    end

    assign dout = (lane == LANE16) ? sh[LANE_W-1:0] : {8'h00, sh[7:0]};
    assign word = sh;

    // R2: loading and stepping never happen in the same cycle
    p_load_step_r2: assert property (@(posedge clk) disable iff (rst)
        !(load && step));

endmodule

// File: rtl/xpp_ctrl.sv
module xpp_ctrl
    import xpp_pkg::*;
#(
    parameter int AW = 16,
    localparam int XA = AW + 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_waddr,
    input  logic             cfg_lane16,
    input  logic [DUR_W-1:0] cfg_dur,
    input  logic             tmr_last,
    output logic             req_ready,
    output logic             tmr_load,
    output logic [DUR_W-1:0] tmr_dur,
    output logic             pk_load,
    output logic             pk_step,
    output lane_e            job_lane,
    output logic [XA-1:0]    xm_addr,
    output logic             xm_rd,
    output logic             xm_wr,
    output logic             xm_drive,
    output logic             page_cross,
    output logic             rsp_valid
);

    xpp_state_e    st, st_n;
    job_t          job;
    logic [XA-1:0] xaddr, prev_addr, start_addr;
    logic          has_prev;
    logic [2:0]    done_cnt;
    logic          accept, acc_end, hit_new, hit_next, last_piece;
    lane_e         in_lane;

    assign in_lane    = lane_e'(cfg_lane16);
    assign accept     = (st == ST_IDLE) && req_valid;
    assign acc_end    = (st == ST_ACC) && tmr_last;
    assign start_addr = (in_lane == LANE16) ? {1'b0, req_waddr, 1'b0} : {req_waddr, 2'b00};
    assign hit_new    = has_prev && (start_addr == prev_addr + XA'(1))
                        && (start_addr[PAGE_LSB-1:0] == '0);
    assign hit_next   = has_prev && (xaddr == prev_addr + XA'(1))
                        && (xaddr[PAGE_LSB-1:0] == '0);
    assign last_piece = (done_cnt == 3'(piece_cnt(job.lane) - 3'd1));

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: if (accept) st_n = hit_new ? ST_PAGE : ST_ACC;
            ST_PAGE: st_n = ST_ACC;
            ST_ACC:  if (tmr_last) st_n = ST_GAP;
            ST_GAP: begin
                if (done_cnt == piece_cnt(job.lane))
                    st_n = ST_IDLE;
                else
                    st_n = hit_next ? ST_PAGE : ST_ACC;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            job       <= '0;
            xaddr     <= '0;
            prev_addr <= '0;
            has_prev  <= 1'b0;
            done_cnt  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            st        <= st_n;
            rsp_valid <= acc_end && !job.wr && last_piece;
            if (accept) begin
                job      <= '{wr: req_write, lane: in_lane, dur: clamp_dur(cfg_dur)};
                xaddr    <= start_addr;
                done_cnt <= '0;
            end else if (acc_end) begin
                prev_addr <= xaddr;
                has_prev  <= 1'b1;
                xaddr     <= xaddr + XA'(1);
                done_cnt  <= done_cnt + 3'd1;
            end
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign tmr_load   = (st_n == ST_ACC) && (st != ST_ACC);
    assign tmr_dur    = (st == ST_IDLE) ? clamp_dur(cfg_dur) : job.dur;
    assign pk_load    = accept;
    assign pk_step    = acc_end;
    assign job_lane   = job.lane;
    assign xm_addr    = xaddr;
    assign xm_rd      = (st == ST_ACC) && !job.wr;
    assign xm_wr      = (st == ST_ACC) && job.wr;
    assign xm_drive   = job.wr && (st != ST_IDLE);
    assign page_cross = (st == ST_PAGE);

    // R1: an idle port never strobes the external memory
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(xm_rd || xm_wr));

    // R5: every access runs with a clamped duration
    p_dur_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACC) |-> (job.dur >= DUR_W'(DUR_LO) && job.dur <= DUR_W'(DUR_HI)));

    // R6: the cycle after the final strobe cycle is idle
    p_gap_after_acc_r6: assert property (@(posedge clk) disable iff (rst)
        acc_end |=> !(xm_rd || xm_wr));

    // R7: read completion is a single-cycle pulse
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: the inserted page idle cycle is followed by an access
    p_page_then_acc_r8: assert property (@(posedge clk) disable iff (rst)
        page_cross |=> (xm_rd || xm_wr));

    // R9: no contention between port drive and a read
    p_drive_vs_read_r9: assert property (@(posedge clk) disable iff (rst)
        xm_rd |-> !xm_drive);

endmodule

// File: rtl/xmem_pack_port.sv
module xmem_pack_port
    import xpp_pkg::*;
#(
    parameter int AW = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_lane16,
    input  logic [DUR_W-1:0]  cfg_dur,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_waddr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [AW+1:0]     xm_addr,
    output logic              xm_rd,
    output logic              xm_wr,
    output logic              xm_drive,
    output logic [LANE_W-1:0] xm_dout,
    input  logic [LANE_W-1:0] xm_din,
    output logic              page_cross
);

    logic             tmr_load, tmr_last, pk_load, pk_step;
    logic [DUR_W-1:0] tmr_dur;
    lane_e            job_lane;

    xpp_ctrl #(.AW(AW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_waddr  (req_waddr),
        .cfg_lane16 (cfg_lane16),
        .cfg_dur    (cfg_dur),
        .tmr_last   (tmr_last),
        .req_ready  (req_ready),
        .tmr_load   (tmr_load),
        .tmr_dur    (tmr_dur),
        .pk_load    (pk_load),
        .pk_step    (pk_step),
        .job_lane   (job_lane),
        .xm_addr    (xm_addr),
        .xm_rd      (xm_rd),
        .xm_wr      (xm_wr),
        .xm_drive   (xm_drive),
        .page_cross (page_cross),
        .rsp_valid  (rsp_valid)
    );

    xpp_timer timer_i (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .dur  (tmr_dur),
        .last (tmr_last)
    );

    xpp_pack pack_i (
        .clk   (clk),
        .rst   (rst),
        .load  (pk_load),
        .step  (pk_step),
        .lane  (job_lane),
        .wdata (req_wdata),
        .din   (xm_din),
        .dout  (xm_dout),
        .word  (rsp_data)
    );

    // R4: the two strobes are mutually exclusive
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !(xm_rd && xm_wr));

    // R4: the address holds while a read strobe continues
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (xm_rd && $past(xm_rd)) |-> $stable(xm_addr));

endmodule

// File: tb/xmem_pack_port_tb_top.sv
module xmem_pack_port_tb_top;
    import xpp_pkg::*;

    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int XA    = AW + 2;
    localparam int MEM_N = 1024;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_lane16;
    logic [5:0]        cfg_dur;
    logic              req_valid, req_ready, req_write;
    logic [AW-1:0]     req_waddr;
    logic [31:0]       req_wdata;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic [XA-1:0]     xm_addr;
    logic              xm_rd, xm_wr, xm_drive, page_cross;
    logic [15:0]       xm_dout, xm_din;

    always #(CLK_P/2) clk = ~clk;

    xmem_pack_port #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_lane16(cfg_lane16), .cfg_dur(cfg_dur),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_waddr(req_waddr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .xm_addr(xm_addr), .xm_rd(xm_rd), .xm_wr(xm_wr), .xm_drive(xm_drive),
        .xm_dout(xm_dout), .xm_din(xm_din), .page_cross(page_cross)
    );

    typedef struct packed {
        logic          rd, wr, pg, drv, rsp;
        logic [XA-1:0] addr;
        logic [15:0]   dout;
        logic [31:0]   rdata;
    } rec_t;

    rec_t        q[$];
    logic [15:0] mem    [MEM_N];
    logic [15:0] shadow [MEM_N];
    int          n_chk = 0, n_bad = 0, m_prev = 0;
    bit          m_has_prev = 0, done_flag = 0;
    string       ctx = "reset";

    function automatic logic [15:0] init_val(input int i);
        return 16'((i * 37) ^ 16'hA5C3);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s [%s] actual=%0h expected=%0h t=%0t", tag, what, ctx, act, exp, $time);
        end
    endtask

    // external memory model: 16-bit cells, write on each strobe cycle
    assign xm_din = xm_rd ? mem[xm_addr[9:0]] : 16'h0BAD;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= init_val(i);
        end else if (xm_wr) begin
            mem[xm_addr[9:0]] <= xm_dout;
        end
    end

    // reference model: builds the expected cycle stream of one word
    task automatic model_job(input bit wr, input logic [AW-1:0] wa, input logic [31:0] wd,
                             input bit l16, input logic [5:0] draw);
        int          d, n, base, a;
        rec_t        r;
        logic [15:0] lv;
        logic [31:0] rw;
        d    = (draw < 6'd3) ? 3 : ((draw > 6'd32) ? 32 : int'(draw));
        n    = l16 ? 2 : 4;
        base = l16 ? int'(wa) * 2 : int'(wa) * 4;
        rw   = '0;
        for (int k = 0; k < n; k++) begin
            a = base + k;
            if (m_has_prev && a == m_prev + 1 && (a % 256) == 0) begin
                r = '0; r.pg = 1'b1; r.drv = wr; q.push_back(r);
            end
            lv = l16 ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
            if (wr) shadow[a % MEM_N] = lv;
            if (l16) rw[16*k +: 16] = shadow[a % MEM_N];
            else     rw[8*k +: 8]   = shadow[a % MEM_N][7:0];
            for (int c = 0; c < d; c++) begin
                r = '0; r.rd = !wr; r.wr = wr; r.addr = XA'(a); r.dout = lv; r.drv = wr;
                q.push_back(r);
            end
            r = '0; r.drv = wr; r.rsp = (!wr && k == n - 1); r.rdata = rw;
            q.push_back(r);
            m_prev = a;
            m_has_prev = 1'b1;
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        rec_t e;
        bit   idle_exp;
        if (rst) begin
            for (int i = 0; i < MEM_N; i++) shadow[i] = init_val(i);
            q.delete();
            m_has_prev = 1'b0;
        end else begin
            idle_exp = (q.size() == 0);
            if (idle_exp) e = '0;
            else          e = q.pop_front();
            chk(req_ready == idle_exp, "R1", "req_ready", 32'(req_ready), 32'(idle_exp));
            chk(xm_rd == e.rd, "R4 R5 R6", "xm_rd", 32'(xm_rd), 32'(e.rd));
            chk(xm_wr == e.wr, "R4 R5 R6", "xm_wr", 32'(xm_wr), 32'(e.wr));
            if (e.rd || e.wr)
                chk(xm_addr == e.addr, "R2 R3", "xm_addr", 32'(xm_addr), 32'(e.addr));
            if (e.wr)
                chk(xm_dout == e.dout, "R2 R3", "xm_dout", 32'(xm_dout), 32'(e.dout));
            chk(page_cross == e.pg, "R8", "page_cross", 32'(page_cross), 32'(e.pg));
            chk(xm_drive == e.drv, "R9", "xm_drive", 32'(xm_drive), 32'(e.drv));
            chk(rsp_valid == e.rsp, "R7 R11", "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
            if (e.rsp)
                chk(rsp_data == e.rdata, "R7", "rsp_data", rsp_data, e.rdata);
            if (req_valid && req_ready)
                model_job(req_write, req_waddr, req_wdata, cfg_lane16, cfg_dur);
        end
    end

    // offer a word, wait for it to be taken, then disturb the config (R10)
    task automatic send(input string tag, input bit wr, input int wa, input logic [31:0] wd,
                        input bit l16, input int dur);
        @(posedge clk); #1;
        ctx        = tag;
        req_valid  = 1'b1;
        req_write  = wr;
        req_waddr  = AW'(wa);
        req_wdata  = wd;
        cfg_lane16 = l16;
        cfg_dur    = 6'(dur);
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid  = 1'b0;
        req_wdata  = ~wd;
        cfg_lane16 = !l16;
        cfg_dur    = 6'd63 - 6'(dur);
    endtask

    task automatic drain();
        forever begin
            @(negedge clk);
            if (req_ready && q.size() == 0) break;
        end
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int mism;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_waddr = '0;
        req_wdata = '0; cfg_lane16 = 1'b0; cfg_dur = 6'd3;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 1);
        chk(!xm_rd && !xm_wr, "R1", "reset strobes", 32'({xm_rd, xm_wr}), 0);
        chk(!page_cross && !xm_drive && !rsp_valid, "R1", "reset flags",
            32'({page_cross, xm_drive, rsp_valid}), 0);
        @(posedge clk); #1; rst = 1'b0;

        send("R2 8-bit write dur 3",            1, 10,  32'h1122_3344, 0, 3);
        send("R7 8-bit read back dur 5",        0, 10,  32'h0,         0, 5);
        send("R5 16-bit write dur 0 clamps",    1, 40,  32'hCAFE_BABE, 1, 0);
        send("R5 16-bit read dur 40 clamps",    0, 40,  32'h0,         1, 40);
        send("R7 8-bit read ignores high byte", 0, 20,  32'h0,         0, 4);
        send("R3 16-bit read preset data",      0, 21,  32'h0,         1, 3);
        send("R8 16-bit write before boundary", 1, 127, 32'hA1B2_C3D4, 1, 3);
        send("R8 16-bit write after boundary",  1, 128, 32'h5566_7788, 1, 3);
        send("R8 8-bit read before boundary",   0, 63,  32'h0,         0, 3);
        send("R8 8-bit read after boundary",    0, 64,  32'h0,         0, 4);
        send("R8 jump no cross",                1, 200, 32'h0F1E_2D3C, 0, 3);
        send("R8 jump onto boundary",           1, 128, 32'h9988_7766, 0, 3);
        send("R10 cfg change mid word",         1, 30,  32'hDEAD_BEEF, 0, 4);
        send("R10 read after cfg change",       0, 30,  32'h0,         0, 63);
        send("R11 16-bit write no response",    1, 100, 32'h1357_9BDF, 1, 32);
        send("R3 16-bit read back",             0, 100, 32'h0,         1, 6);
        drain();

        ctx  = "final image";
        mism = 0;
        for (int i = 0; i < MEM_N; i++) if (mem[i] !== shadow[i]) mism++;
        chk(mism == 0, "R2 R3", "external memory mismatches", 32'(mism), 0);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule